// File: doc/BRIEF.md
# Dual-Channel Indirect Register Access

This block is the host-side register front end of a two-channel serial controller. The host uses one byte-wide bus. A channel select picks channel A or channel B, and a control/data select picks between the control path and the data port. A read strobe and a write strobe mark each access. On the control path every register sits behind a per-channel pointer. Selecting a register other than zero takes two steps. The host first writes register 0 with the register number, and the next control access then reads or writes that register.

A write to register 0 carries three fields. The low bits load the pointer. A three-bit command field produces a one-cycle command pulse toward the interrupt logic. A separate two-bit field produces a CRC-reset pulse. Both the vector register and the master interrupt register are single copies that either channel can reach. The interrupt-pending read register answers only on channel A. Status values for the read side arrive on plain input ports. The two baud time-constant bytes of each channel are presented as one 16-bit word.

Top module: `dual_chan_regif`

## Requirements
- R1: After synchronous reset both pointers are 0, every stored write register reads as 0 on `cfg_a`, `cfg_b`, `tc_a` and `tc_b`, all command, CRC and load pulses are low, and `rdata` is 0 while `rd_stb` is low.
- R2: A control write (`cd_sel`=0) to a channel whose pointer is 0 loads that pointer with `wdata[2:0]`, plus 8 when `wdata[5:3]` equals 3'b001.
- R3: Any control read or write to a channel whose pointer is non-zero accesses the selected register and returns that pointer to 0. Data-port accesses (`cd_sel`=1) leave the pointer unchanged.
- R4: In a pointer-0 control write, `wdata[5:3]` selects a command. 3'b010 resets external/status, 3'b100 arms receive-next, 3'b101 resets transmit, 3'b110 resets errors and 3'b111 resets under-service. The command pulses high on the matching output bit of that channel (bit 1 = A, bit 0 = B) for exactly the one cycle after the write. Codes 000, 001 and 011 pulse nothing.
- R5: In the same write, a non-zero `wdata[7:6]` appears on that channel's `crc_cmd` field (bits 3:2 = A, 1:0 = B) for one cycle. This happens independently of the command field.
- R6: Write registers 2 and 9 each have a single copy. A write through either channel updates byte 2 or byte 9 of both `cfg_a` and `cfg_b`.
- R7: Write registers 1, 3-7, 10-15 are stored per channel, and a write on one channel leaves the other channel's copy unchanged. Byte i of `cfg_x` is register i, and bytes 0 and 8 read 0. `tc_x` is {register 13, register 12}.
- R8: Read register 3 on channel A returns {2'b00, `ip_in`}, where `ip_in[5:3]` holds channel A's flags and `ip_in[2:0]` holds channel B's. On channel B it returns 0x00.
- R9: Read register 8 and a data-port read both return that channel's byte of `rx_in`.
- R10: Read register numbers 4, 5, 6, 7, 9, 11 and 14 return 0x00.
- R11: A data-port write, or a write to register 8, raises that channel's `tx_load` bit for one cycle with `tx_byte` equal to the written byte.
- R12: A control read with pointer 0 returns that channel's byte of `rr0_in` and leaves the pointer at 0.
- R13: Read register 1 returns `rr1_in` and read register 10 returns `rr10_in`. Read register 2 returns the stored vector on channel A and `vec_b_in` on channel B. Read registers 12, 13 and 15 return the stored write values of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_sel | input | 1 | Channel select, 1 = A, 0 = B |
| cd_sel | input | 1 | 0 = control path, 1 = data port |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_stb is high |
| rr0_in | input | 16 | Buffer status per channel, A in high byte |
| rr1_in | input | 16 | Special receive status per channel |
| rr10_in | input | 16 | Miscellaneous status per channel |
| rx_in | input | 16 | Received byte per channel |
| ip_in | input | 6 | Interrupt-pending flags, A in 5:3, B in 2:0 |
| vec_b_in | input | 8 | Status-modified vector shown on channel B |
| cfg_a | output | 128 | Channel A write-register view, byte i = register i |
| cfg_b | output | 128 | Channel B write-register view |
| tc_a | output | 16 | Channel A baud time constant |
| tc_b | output | 16 | Channel B baud time constant |
| cmd_xs | output | 2 | External/status reset pulse per channel |
| cmd_rxnext | output | 2 | Receive-next arm pulse per channel |
| cmd_txrst | output | 2 | Transmit-pending reset pulse per channel |
| cmd_errrst | output | 2 | Error reset pulse per channel |
| cmd_ius | output | 2 | Under-service reset pulse per channel |
| crc_cmd | output | 4 | CRC-reset code per channel, 0 when idle |
| tx_load | output | 2 | Transmit byte load pulse per channel |
| tx_byte | output | 8 | Byte to transmit |

## Verification
A single register-0 write can load a new pointer, fire a command pulse and fire a CRC-reset pulse at the same clock edge. The bench provokes this with bytes that fill all three fields at once, for example a reset-external/status code combined with pointer 4, or with CRC code 3 and pointer 1. It judges the result by checking the pulses in the cycle after the write. It then uses the very next control access to show that the pointer landed on the intended register. A second overlap is a data-port access while a pointer is pending. The bench checks that the following control read still reaches the selected register.

// File: rtl/regif_pkg.sv
package regif_pkg;

    localparam int DW   = 8;
    localparam int NREG = 16;
    localparam int AW   = $clog2(NREG);
    localparam int NCH  = 2;
    localparam int CHW  = $clog2(NCH);
    localparam int IPF  = 3;
    localparam int IPW  = IPF * NCH;
    localparam int CRCW = 2;

    localparam logic [CHW-1:0] CH_A = CHW'(1);
    localparam logic [CHW-1:0] CH_B = CHW'(0);

    localparam logic [AW-1:0] R_PTR  = AW'(0);
    localparam logic [AW-1:0] R_ST1  = AW'(1);
    localparam logic [AW-1:0] R_VEC  = AW'(2);
    localparam logic [AW-1:0] R_IP   = AW'(3);
    localparam logic [AW-1:0] R_TXD  = AW'(8);
    localparam logic [AW-1:0] R_MIC  = AW'(9);
    localparam logic [AW-1:0] R_ST10 = AW'(10);
    localparam logic [AW-1:0] R_TCL  = AW'(12);
    localparam logic [AW-1:0] R_TCH  = AW'(13);
    localparam logic [AW-1:0] R_XSEN = AW'(15);

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_UPPER  = 3'd1,
        CMD_XS     = 3'd2,
        CMD_RSV    = 3'd3,
        CMD_RXNEXT = 3'd4,
        CMD_TXRST  = 3'd5,
        CMD_ERR    = 3'd6,
        CMD_IUS    = 3'd7
    } cmd_e;

    typedef struct packed {
        logic xs_rst;
        logic rx_next;
        logic tx_rst;
        logic err_rst;
        logic ius_rst;
    } cmd_pulse_t;

    function automatic cmd_pulse_t decode_cmd(input cmd_e code);
        cmd_pulse_t p;
        p = '0;
        case (code)
            CMD_XS:     p.xs_rst  = 1'b1;
            CMD_RXNEXT: p.rx_next = 1'b1;
            CMD_TXRST:  p.tx_rst  = 1'b1;
            CMD_ERR:    p.err_rst = 1'b1;
            CMD_IUS:    p.ius_rst = 1'b1;
            default:    p = '0;
        endcase
        return p;
    endfunction

    function automatic logic [AW-1:0] target_reg(input logic [DW-1:0] w);
        return {(cmd_e'(w[5:3]) == CMD_UPPER), w[2:0]};
    endfunction

endpackage

// File: rtl/regif_ptr.sv
module regif_ptr
    import regif_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ctl_sel,
    input  logic            rd,
    input  logic            wr,
    input  logic [DW-1:0]   wdata,
    output logic [AW-1:0]   ptr,
    output cmd_pulse_t      cmd,
    output logic [CRCW-1:0] crc
);

    logic access;
    assign access = ctl_sel && (rd || wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= R_PTR;
            cmd <= '0;
            crc <= '0;
        end else begin
            cmd <= '0;
            crc <= '0;
            if (access) begin
                if (ptr != R_PTR) begin
                    ptr <= R_PTR;
                end else if (wr) begin
                    ptr <= target_reg(wdata);
                    cmd <= decode_cmd(cmd_e'(wdata[5:3]));
                    crc <= wdata[7:6];
                end
            end
        end
    end

    a_r3_ptr_returns: assert property (@(posedge clk) disable iff (rst)
        (access && ptr != R_PTR) |=> (ptr == R_PTR));

    a_r3_ptr_holds: assert property (@(posedge clk) disable iff (rst)
        !access |=> $stable(ptr));

    a_r4_cmd_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd));

    a_r4_cmd_cause: assert property (@(posedge clk) disable iff (rst)
        (cmd != '0) |-> $past(ctl_sel && wr && ptr == R_PTR));

    a_r5_crc_cause: assert property (@(posedge clk) disable iff (rst)
        (crc != '0) |-> $past(ctl_sel && wr && ptr == R_PTR));

endmodule

// File: rtl/regif_bank.sv
module regif_bank
    import regif_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [CHW-1:0]       ch,
    input  logic [AW-1:0]        idx,
    input  logic [DW-1:0]        wdata,
    input  logic                 dp_wr,
    output logic [NREG*DW-1:0]   view [NCH],
    output logic [NCH-1:0]       tx_load,
    output logic [DW-1:0]        tx_byte
);

    logic [DW-1:0] shared_vec;
    logic [DW-1:0] shared_mic;

    always_ff @(posedge clk) begin
        if (rst) begin
            shared_vec <= '0;
            shared_mic <= '0;
        end else if (we) begin
            if (idx == R_VEC) shared_vec <= wdata;
            if (idx == R_MIC) shared_mic <= wdata;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            localparam logic [AW-1:0] RI = AW'(r);
            if (RI == R_VEC) begin : g_vec
                assign view[c][r*DW +: DW] = shared_vec;
            end else if (RI == R_MIC) begin : g_mic
                assign view[c][r*DW +: DW] = shared_mic;
            end else if (RI == R_PTR || RI == R_TXD) begin : g_none
                assign view[c][r*DW +: DW] = '0;
            end else begin : g_own
                logic [DW-1:0] q;
                always_ff @(posedge clk) begin
                    if (rst) q <= '0;
                    else if (we && ch == CHW'(c) && idx == RI) q <= wdata;
                end
                assign view[c][r*DW +: DW] = q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_load <= '0;
            tx_byte <= '0;
        end else begin
            tx_load <= '0;
            if (dp_wr || (we && idx == R_TXD)) begin
                tx_load[ch] <= 1'b1;
                tx_byte     <= wdata;
            end
        end
    end

    a_r6_shared_quiet: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(shared_vec) && $stable(shared_mic)));

    a_r11_load_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tx_load));

    a_r11_load_cause: assert property (@(posedge clk) disable iff (rst)
        (tx_load != '0) |-> $past(dp_wr || we));

endmodule

// File: rtl/regif_rdmux.sv
module regif_rdmux
    import regif_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd,
    input  logic                 cd,
    input  logic [CHW-1:0]       ch,
    input  logic [AW-1:0]        ptr,
    input  logic [NCH*DW-1:0]    rr0_in,
    input  logic [NCH*DW-1:0]    rr1_in,
    input  logic [NCH*DW-1:0]    rr10_in,
    input  logic [NCH*DW-1:0]    rx_in,
    input  logic [IPW-1:0]       ip_in,
    input  logic [DW-1:0]        vec_b_in,
    input  logic [NREG*DW-1:0]   view [NCH],
    output logic [DW-1:0]        rdata
);

    logic [DW-1:0] stored;
    logic [DW-1:0] rx_ch;
    logic [DW-1:0] val;

    assign stored = view[ch][ptr*DW +: DW];
    assign rx_ch  = rx_in[ch*DW +: DW];

    always_comb begin
        val = '0;
        if (cd) begin
            val = rx_ch;
        end else begin
            case (ptr)
                R_PTR:  val = rr0_in[ch*DW +: DW];
                R_ST1:  val = rr1_in[ch*DW +: DW];
                R_VEC:  val = (ch == CH_A) ? stored : vec_b_in;
                R_IP:   val = (ch == CH_A) ? {{(DW-IPW){1'b0}}, ip_in} : '0;
                R_TXD:  val = rx_ch;
                R_ST10: val = rr10_in[ch*DW +: DW];
                R_TCL, R_TCH, R_XSEN: val = stored;
                default: val = '0;
            endcase
        end
    end

    assign rdata = rd ? val : '0;

    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd |-> (rdata == '0));

    a_r8_ip_hidden_on_b: assert property (@(posedge clk) disable iff (rst)
        (rd && !cd && ch == CH_B && ptr == R_IP) |-> (rdata == '0));

    a_r9_rr8_is_data: assert property (@(posedge clk) disable iff (rst)
        (rd && !cd && ptr == R_TXD) |-> (rdata == rx_in[ch*DW +: DW]));

endmodule

// File: rtl/dual_chan_regif.sv
module dual_chan_regif
    import regif_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ch_sel,
    input  logic                    cd_sel,
    input  logic                    rd_stb,
    input  logic                    wr_stb,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    input  logic [NCH*DW-1:0]       rr0_in,
    input  logic [NCH*DW-1:0]       rr1_in,
    input  logic [NCH*DW-1:0]       rr10_in,
    input  logic [NCH*DW-1:0]       rx_in,
    input  logic [IPW-1:0]          ip_in,
    input  logic [DW-1:0]           vec_b_in,
    output logic [NREG*DW-1:0]      cfg_a,
    output logic [NREG*DW-1:0]      cfg_b,
    output logic [2*DW-1:0]         tc_a,
    output logic [2*DW-1:0]         tc_b,
    output logic [NCH-1:0]          cmd_xs,
    output logic [NCH-1:0]          cmd_rxnext,
    output logic [NCH-1:0]          cmd_txrst,
    output logic [NCH-1:0]          cmd_errrst,
    output logic [NCH-1:0]          cmd_ius,
    output logic [NCH*CRCW-1:0]     crc_cmd,
    output logic [NCH-1:0]          tx_load,
    output logic [DW-1:0]           tx_byte
);

    logic [AW-1:0]       ptr_w [NCH];
    cmd_pulse_t          cmd_w [NCH];
    logic [NREG*DW-1:0]  view  [NCH];
    logic [AW-1:0]       ptr_cur;
    logic                reg_we;
    logic                dp_wr;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic sel_c;
        assign sel_c = (ch_sel == CHW'(c)) && !cd_sel;

        regif_ptr u_ptr (
            .clk     (clk),
            .rst     (rst),
            .ctl_sel (sel_c),
            .rd      (rd_stb),
            .wr      (wr_stb),
            .wdata   (wdata),
            .ptr     (ptr_w[c]),
            .cmd     (cmd_w[c]),
            .crc     (crc_cmd[c*CRCW +: CRCW])
        );

        assign cmd_xs[c]     = cmd_w[c].xs_rst;
        assign cmd_rxnext[c] = cmd_w[c].rx_next;
        assign cmd_txrst[c]  = cmd_w[c].tx_rst;
        assign cmd_errrst[c] = cmd_w[c].err_rst;
        assign cmd_ius[c]    = cmd_w[c].ius_rst;
    end

    assign ptr_cur = ptr_w[ch_sel];
    assign reg_we  = !cd_sel && wr_stb && (ptr_cur != R_PTR);
    assign dp_wr   = cd_sel && wr_stb;

    regif_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .ch      (ch_sel),
        .idx     (ptr_cur),
        .wdata   (wdata),
        .dp_wr   (dp_wr),
        .view    (view),
        .tx_load (tx_load),
        .tx_byte (tx_byte)
    );

    regif_rdmux u_rdmux (
        .clk      (clk),
        .rst      (rst),
        .rd       (rd_stb),
        .cd       (cd_sel),
        .ch       (ch_sel),
        .ptr      (ptr_cur),
        .rr0_in   (rr0_in),
        .rr1_in   (rr1_in),
        .rr10_in  (rr10_in),
        .rx_in    (rx_in),
        .ip_in    (ip_in),
        .vec_b_in (vec_b_in),
        .view     (view),
        .rdata    (rdata)
    );

    assign cfg_a = view[CH_A];
    assign cfg_b = view[CH_B];
    assign tc_a  = {view[CH_A][R_TCH*DW +: DW], view[CH_A][R_TCL*DW +: DW]};
    assign tc_b  = {view[CH_B][R_TCH*DW +: DW], view[CH_B][R_TCL*DW +: DW]};

    a_r7_tc_follows_cfg: assert property (@(posedge clk) disable iff (rst)
        (tc_a[DW-1:0] == cfg_a[R_TCL*DW +: DW]) && (tc_b[DW-1:0] == cfg_b[R_TCL*DW +: DW]));

    a_r6_shared_match: assert property (@(posedge clk) disable iff (rst)
        cfg_a[R_MIC*DW +: DW] == cfg_b[R_MIC*DW +: DW]);

endmodule

// File: tb/dual_chan_regif_tb.sv
module dual_chan_regif_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ch_sel = 1'b0, cd_sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic [15:0]  rr0_in  = {8'hA5, 8'h5A};
    logic [15:0]  rr1_in  = {8'h81, 8'h01};
    logic [15:0]  rr10_in = {8'h40, 8'h04};
    logic [15:0]  rx_in   = {8'hC3, 8'h3C};
    logic [5:0]   ip_in   = 6'b101011;
    logic [7:0]   vec_b_in = 8'h0E;
    logic [127:0] cfg_a, cfg_b;
    logic [15:0]  tc_a, tc_b;
    logic [1:0]   cmd_xs, cmd_rxnext, cmd_txrst, cmd_errrst, cmd_ius, tx_load;
    logic [3:0]   crc_cmd;
    logic [7:0]   tx_byte;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    localparam logic A = 1'b1;
    localparam logic B = 1'b0;

    always #5 clk = ~clk;

    dual_chan_regif u_dut (
        .clk(clk), .rst(rst), .ch_sel(ch_sel), .cd_sel(cd_sel),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata),
        .rr0_in(rr0_in), .rr1_in(rr1_in), .rr10_in(rr10_in), .rx_in(rx_in),
        .ip_in(ip_in), .vec_b_in(vec_b_in), .cfg_a(cfg_a), .cfg_b(cfg_b),
        .tc_a(tc_a), .tc_b(tc_b), .cmd_xs(cmd_xs), .cmd_rxnext(cmd_rxnext),
        .cmd_txrst(cmd_txrst), .cmd_errrst(cmd_errrst), .cmd_ius(cmd_ius),
        .crc_cmd(crc_cmd), .tx_load(tx_load), .tx_byte(tx_byte)
    );

    task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data while a read is on the bus.
    always @(negedge clk) begin
        if (!rst && rd_stb) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL unexpected-read actual=%0h expected=none", rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rdata !== e) begin
                    failures++;
                    $display("FAIL %s actual=%0h expected=%0h", t, rdata, e);
                end
            end
        end
    end

    task automatic acc(input logic c, input logic d, input logic r, input logic w, input logic [7:0] v);
        ch_sel = c; cd_sel = d; rd_stb = r; wr_stb = w; wdata = v;
        @(posedge clk); #1;
        rd_stb = 1'b0; wr_stb = 1'b0;
    endtask

    function automatic logic [7:0] pbyte(input int r);
        return (r >= 8) ? (8'h08 | 8'(r - 8)) : 8'(r);
    endfunction

    task automatic wr_ctl(input logic c, input logic [7:0] v);
        acc(c, 1'b0, 1'b0, 1'b1, v);
    endtask

    task automatic wr_reg(input logic c, input int r, input logic [7:0] v);
        wr_ctl(c, pbyte(r));
        wr_ctl(c, v);
    endtask

    task automatic exp_rd(input logic c, input logic d, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        acc(c, d, 1'b1, 1'b0, 8'h00);
    endtask

    task automatic rd_reg(input logic c, input int r, input logic [7:0] e, input string tag);
        if (r != 0) wr_ctl(c, pbyte(r));
        exp_rd(c, 1'b0, e, tag);
    endtask

    task automatic pulses_zero(input string tag);
        chk({cmd_xs, cmd_rxnext, cmd_txrst, cmd_errrst, cmd_ius, crc_cmd, tx_load}, '0, tag);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk({cfg_a, cfg_b}, '0, "R1 cfg after reset");
        chk({tc_a, tc_b}, '0, "R1 tc after reset");
        pulses_zero("R1 pulses after reset");
        chk(rdata, 8'h00, "R1 idle rdata");

        // R12 pointer-0 read returns buffer status
        rd_reg(A, 0, 8'hA5, "R12 rr0 chan A");
        rd_reg(B, 0, 8'h5A, "R12 rr0 chan B");

        // R2 R7 time constants, upper-half pointer
        wr_reg(A, 12, 8'h34);
        wr_reg(A, 13, 8'h12);
        wr_reg(B, 12, 8'h78);
        wr_reg(B, 13, 8'h56);
        chk(tc_a, 16'h1234, "R7 tc_a");
        chk(tc_b, 16'h5678, "R7 tc_b");
        rd_reg(A, 13, 8'h12, "R2 R13 read reg13 chan A");
        rd_reg(B, 12, 8'h78, "R13 read reg12 chan B");

        // R3 pointer returned to 0 after the access
        exp_rd(A, 1'b0, 8'hA5, "R3 pointer back to zero");

        // R3 data port does not disturb a pending pointer
        wr_ctl(A, pbyte(1));
        exp_rd(A, 1'b1, 8'hC3, "R9 data port read A");
        exp_rd(A, 1'b0, 8'h81, "R3 pointer kept across data port");
        rd_reg(B, 10, 8'h04, "R13 rr10 chan B");

        // R4 commands
        wr_ctl(A, 8'h10);
        chk(cmd_xs, 2'b10, "R4 xs reset pulse A");
        @(posedge clk); #1;
        chk(cmd_xs, 2'b00, "R4 xs pulse one cycle");
        wr_ctl(B, 8'h28);
        chk({cmd_txrst, cmd_xs}, 4'b0100, "R4 tx reset pulse B");
        wr_ctl(A, 8'h20);
        chk(cmd_rxnext, 2'b10, "R4 rx-next pulse A");
        wr_ctl(B, 8'h30);
        chk(cmd_errrst, 2'b01, "R4 error reset pulse B");
        wr_ctl(A, 8'h38);
        chk(cmd_ius, 2'b10, "R4 ius reset pulse A");
        wr_ctl(B, 8'h18);
        pulses_zero("R4 reserved code silent");
        exp_rd(B, 1'b0, 8'h5A, "R4 reserved code leaves pointer 0");

        // Overlap: command + pointer in one write
        wr_ctl(A, 8'h14);
        chk({cmd_xs, crc_cmd}, {2'b10, 4'b0000}, "R4 command with pointer");
        wr_ctl(A, 8'hAA);
        chk(cfg_a[4*8 +: 8], 8'hAA, "R2 pointer loaded with command");
        chk(cfg_b[4*8 +: 8], 8'h00, "R7 other channel untouched");

        // R5 CRC field with command and pointer
        wr_ctl(A, 8'hD1);
        chk({cmd_xs, crc_cmd}, {2'b10, 4'b1100}, "R5 crc code A with command");
        exp_rd(A, 1'b0, 8'h81, "R5 pointer 1 after crc write");
        wr_ctl(B, 8'h40);
        chk({cmd_xs, cmd_rxnext, cmd_txrst, cmd_errrst, cmd_ius, crc_cmd}, {10'b0, 4'b0001}, "R5 crc alone chan B");

        // R6 shared registers
        wr_reg(B, 9, 8'h09);
        chk({cfg_a[9*8 +: 8], cfg_b[9*8 +: 8]}, 16'h0909, "R6 reg9 shared");
        wr_reg(A, 2, 8'h55);
        chk({cfg_a[2*8 +: 8], cfg_b[2*8 +: 8]}, 16'h5555, "R6 reg2 shared");
        rd_reg(A, 2, 8'h55, "R13 rr2 chan A stored");
        rd_reg(B, 2, 8'h0E, "R13 rr2 chan B status");

        // R8 interrupt pending
        rd_reg(A, 3, 8'h2B, "R8 rr3 chan A");
        rd_reg(B, 3, 8'h00, "R8 rr3 chan B hidden");

        // R9 rr8 equals data port
        rd_reg(B, 8, 8'h3C, "R9 rr8 chan B");
        exp_rd(B, 1'b1, 8'h3C, "R9 data port B");

        // R10 missing read registers
        rd_reg(A, 5, 8'h00, "R10 rr5 zero");
        rd_reg(A, 14, 8'h00, "R10 rr14 zero");
        rd_reg(B, 9, 8'h00, "R10 rr9 zero");

        // R13 reg15 read-back
        wr_reg(B, 15, 8'hF1);
        rd_reg(B, 15, 8'hF1, "R13 rr15 chan B");
        chk(cfg_a[15*8 +: 8], 8'h00, "R7 reg15 chan A untouched");

        // R11 transmit loads
        acc(B, 1'b1, 1'b0, 1'b1, 8'h41);
        chk({tx_load, tx_byte}, {2'b01, 8'h41}, "R11 data port write B");
        @(posedge clk); #1;
        chk(tx_load, 2'b00, "R11 load one cycle");
        wr_reg(A, 8, 8'h42);
        chk({tx_load, tx_byte}, {2'b10, 8'h42}, "R11 reg8 write A");

        @(posedge clk); #1;
        chk(exp_q.size(), 0, "R12 all reads consumed");
        summary();
    end

endmodule